// File: doc/BRIEF.md
# Latched Bidirectional Bus Transceiver

This block links two parallel ports, A and B, through two independent storage banks: one carries data from A toward B, the other from B toward A. Each direction has three active-low controls. A direction select gates the whole path. A capture control lets the bank follow its source port while it is low. A drive control lets the stored word appear on the far port. Data is therefore first taken in and held, then presented later as a separate step, so a word can be parked in the block while the far bus is busy.

Shared-bus behaviour is modelled without tri-state logic. Each port has its own input vector, output vector and output-enable flag, and the surrounding logic or the testbench resolves them onto a real bus. The bank storage uses flip-flops on a system clock. A storage bank is open at any clock edge where its select and capture controls are both low. When either control rises, the bank keeps the word taken at the last open edge. A build-time parameter sets the path to pass data straight through or to invert it in both directions. If both directions drive at once, a contention flag is raised and both ports are still driven as commanded.

Top module: `latched_xcvr`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no bank opened, both banks hold zero, `a_oe_o`, `b_oe_o` and `clash_o` are 0, and each data output shows the stored zero (0x00 straight, 0xFF when INVERT=1).
- R2: On a clock edge where `ab_sel_ni` and `ab_cap_ni` are both 0, the A-to-B bank loads `a_i`. The new word shows on `b_o` right after that edge.
- R3: At the first edge where either `ab_sel_ni` or `ab_cap_ni` has risen to 1, the bank keeps the word loaded at the last edge where both were 0. It does not take the source value present at the rising edge.
- R4: While `ab_cap_ni` is 1, or `ab_sel_ni` is 1, the A-to-B bank keeps its word however `a_i` changes.
- R5: `b_oe_o` is 1 in the same cycle that `ab_sel_ni` and `ab_drv_ni` are both 0.
- R6: `b_oe_o` is 0 whenever `ab_sel_ni` or `ab_drv_ni` is 1, whatever the capture control does.
- R7: With INVERT=0, each data output equals its stored word. With INVERT=1 it is the bitwise complement, in both directions.
- R8: The B-to-A direction follows R2 to R6 with `ba_sel_ni`, `ba_cap_ni` and `ba_drv_ni`, using `b_i` as the source and `a_o`/`a_oe_o` as the destination.
- R9: `clash_o` is 1 in exactly the cycles where `a_oe_o` and `b_oe_o` are both 1. Both outputs stay enabled in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | WIDTH | Data sampled from port A |
| b_i | input | WIDTH | Data sampled from port B |
| ab_sel_ni | input | 1 | A-to-B direction select, active low |
| ab_cap_ni | input | 1 | A-to-B capture control, active low |
| ab_drv_ni | input | 1 | A-to-B drive control, active low |
| ba_sel_ni | input | 1 | B-to-A direction select, active low |
| ba_cap_ni | input | 1 | B-to-A capture control, active low |
| ba_drv_ni | input | 1 | B-to-A drive control, active low |
| a_o | output | WIDTH | Word presented to port A |
| a_oe_o | output | 1 | Port A driver enable |
| b_o | output | WIDTH | Word presented to port B |
| b_oe_o | output | 1 | Port B driver enable |
| clash_o | output | 1 | Both ports driven in the same cycle |

## Verification
The hardest case to reach from the ports is a rising edge on one control at the same edge where the source data changes. This is how a bank that wrongly samples at the closing edge is exposed. The bench sweeps all 64 combinations of the six controls and mixes the bits of a loop counter, so every opening and closing transition happens many times with data that changes on each cycle. Both the straight and the inverting variant are run with the same stimulus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DEF_WIDTH = 8;

  typedef struct packed {
    logic sel_n;
    logic cap_n;
    logic drv_n;
  } dir_ctl_t;
endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH  = DEF_WIDTH,
  parameter bit          INVERT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] src_i,
  input  dir_ctl_t         ctl_i,
  output logic [WIDTH-1:0] dst_o,
  output logic             dst_oe_o
);
  localparam logic [WIDTH-1:0] OUT_MASK = INVERT ? {WIDTH{1'b1}} : '0;

  logic [WIDTH-1:0] store_q;
  logic             open_w;

  assign open_w = ~ctl_i.sel_n & ~ctl_i.cap_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     store_q <= '0;
    else if (open_w) store_q <= src_i;
  end

  generate
    if (INVERT) begin : g_inv
      assign dst_o = ~store_q;
    end else begin : g_thru
      assign dst_o = store_q;
    end
  endgenerate

  assign dst_oe_o = ~ctl_i.sel_n & ~ctl_i.drv_n;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.sel_n && !ctl_i.cap_n) |=> (dst_o == ($past(src_i) ^ OUT_MASK)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.sel_n || ctl_i.cap_n) |=> $stable(dst_o));

  assert_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.sel_n || ctl_i.drv_n) |-> !dst_oe_o);
endmodule

// File: rtl/xcvr_clash.sv
module xcvr_clash (
  input  logic a_oe_i,
  input  logic b_oe_i,
  output logic clash_o
);
  assign clash_o = a_oe_i & b_oe_i;
endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH  = DEF_WIDTH,
  parameter bit          INVERT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ab_sel_ni,
  input  logic             ab_cap_ni,
  input  logic             ab_drv_ni,
  input  logic             ba_sel_ni,
  input  logic             ba_cap_ni,
  input  logic             ba_drv_ni,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o,
  output logic             clash_o
);
  dir_ctl_t ab_ctl, ba_ctl;

  assign ab_ctl = '{sel_n: ab_sel_ni, cap_n: ab_cap_ni, drv_n: ab_drv_ni};
  assign ba_ctl = '{sel_n: ba_sel_ni, cap_n: ba_cap_ni, drv_n: ba_drv_ni};

  xcvr_lane #(.WIDTH(WIDTH), .INVERT(INVERT)) u_ab (
    .clk_i, .rst_ni, .src_i(a_i), .ctl_i(ab_ctl), .dst_o(b_o), .dst_oe_o(b_oe_o)
  );

  xcvr_lane #(.WIDTH(WIDTH), .INVERT(INVERT)) u_ba (
    .clk_i, .rst_ni, .src_i(b_i), .ctl_i(ba_ctl), .dst_o(a_o), .dst_oe_o(a_oe_o)
  );

  xcvr_clash u_clash (.a_oe_i(a_oe_o), .b_oe_i(b_oe_o), .clash_o);

  assert_clash_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash_o |-> (a_oe_o && b_oe_o));

  assert_ba_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_sel_ni |-> !a_oe_o);
endmodule

// File: tb/latched_xcvr_tb.sv
module latched_xcvr_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic ab_sel_ni = 1, ab_cap_ni = 1, ab_drv_ni = 1;
  logic ba_sel_ni = 1, ba_cap_ni = 1, ba_drv_ni = 1;
  logic [W-1:0] a_o, b_o, a_o_x, b_o_x;
  logic a_oe_o, b_oe_o, clash_o, a_oe_x, b_oe_x, clash_x;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;
  bit prev_ab_open = 0, prev_ba_open = 0;

  always #5 clk = ~clk;

  latched_xcvr #(.WIDTH(W), .INVERT(1'b0)) u_dut (
    .clk_i(clk), .rst_ni, .a_i, .b_i, .ab_sel_ni, .ab_cap_ni, .ab_drv_ni,
    .ba_sel_ni, .ba_cap_ni, .ba_drv_ni, .a_o, .a_oe_o, .b_o, .b_oe_o, .clash_o);

  latched_xcvr #(.WIDTH(W), .INVERT(1'b1)) u_dut_inv (
    .clk_i(clk), .rst_ni, .a_i, .b_i, .ab_sel_ni, .ab_cap_ni, .ab_drv_ni,
    .ba_sel_ni, .ba_cap_ni, .ba_drv_ni, .a_o(a_o_x), .a_oe_o(a_oe_x),
    .b_o(b_o_x), .b_oe_o(b_oe_x), .clash_o(clash_x));

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic check_all();
    bit ab_open, ba_open, ab_drv, ba_drv;
    string tb_tag, ta_tag;
    ab_open = !ab_sel_ni && !ab_cap_ni;
    ba_open = !ba_sel_ni && !ba_cap_ni;
    ab_drv  = !ab_sel_ni && !ab_drv_ni;
    ba_drv  = !ba_sel_ni && !ba_drv_ni;
    tb_tag = ab_open ? "R2 b_o load" : (prev_ab_open ? "R3 b_o freeze" : "R4 b_o hold");
    ta_tag = ba_open ? "R8 a_o load" : (prev_ba_open ? "R8 a_o freeze" : "R8 a_o hold");
    chk(tb_tag, b_o, m_ab);
    chk(ta_tag, a_o, m_ba);
    chk("R7 b_o inverted", b_o_x, ~m_ab);
    chk("R7 a_o inverted", a_o_x, ~m_ba);
    chk(ab_drv ? "R5 b_oe on" : "R6 b_oe off", {7'b0, b_oe_o}, {7'b0, ab_drv});
    chk(ba_drv ? "R8 a_oe on" : "R8 a_oe off", {7'b0, a_oe_o}, {7'b0, ba_drv});
    chk("R9 clash", {7'b0, clash_o}, {7'b0, ab_drv && ba_drv});
    chk("R9 clash inv", {7'b0, clash_x}, {7'b0, ab_drv && ba_drv});
  endtask

  task automatic cycle(logic [5:0] ctl, logic [W-1:0] av, logic [W-1:0] bv);
    bit ab_open, ba_open;
    @(negedge clk);
    {ab_sel_ni, ab_cap_ni, ab_drv_ni, ba_sel_ni, ba_cap_ni, ba_drv_ni} = ctl;
    a_i = av;
    b_i = bv;
    ab_open = !ab_sel_ni && !ab_cap_ni;
    ba_open = !ba_sel_ni && !ba_cap_ni;
    @(posedge clk);
    if (ab_open) m_ab = av;
    if (ba_open) m_ba = bv;
    #1;
    check_all();
    prev_ab_open = ab_open;
    prev_ba_open = ba_open;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: state during and after reset
    repeat (3) @(posedge clk);
    #1;
    chk("R1 b_o in reset", b_o, 8'h00);
    chk("R1 a_o inv in reset", a_o_x, 8'hFF);
    chk("R1 oe in reset", {6'b0, a_oe_o, b_oe_o}, 8'h00);
    @(negedge clk);
    rst_ni = 1'b1;
    a_i = 8'h5A;
    b_i = 8'hC3;
    @(posedge clk);
    #1;
    chk("R1 b_o after reset", b_o, 8'h00);
    chk("R1 a_o after reset", a_o, 8'h00);
    chk("R1 clash after reset", {7'b0, clash_o}, 8'h00);

    // R3: close A-to-B by raising select while data changes on the same edge
    cycle(6'b000_111, 8'h11, 8'h22);
    cycle(6'b100_111, 8'hEE, 8'h33);
    chk("R3 select-close keeps prior word", b_o, 8'h11);
    cycle(6'b000_111, 8'h44, 8'h55);
    cycle(6'b010_111, 8'hBB, 8'h66);
    chk("R3 capture-close keeps prior word", b_o, 8'h44);
    // R4: source wanders while capture is high
    for (int k = 0; k < 8; k++) cycle(6'b010_111, 8'(k * 29 + 1), 8'(k * 3));
    chk("R4 held through wandering source", b_o, 8'h44);

    // near-exhaustive sweep over control combinations with changing data
    for (int i = 0; i < 4096; i++) begin
      logic [5:0] c;
      c = 6'(i) ^ 6'(i >> 6) ^ 6'(i >> 3);
      cycle(c, 8'(i * 37 + 5), 8'(i * 91 + 3));
    end

    finish_run();
  end
endmodule